// File: doc/BRIEF.md
# Oversampling Serial Receiver with Receive Queue

This block recovers asynchronous serial frames from a single input line. A shared enable pulse at sixteen times the bit rate drives it. It confirms each start bit at its midpoint, then samples the data bits, the optional parity bit and the first stop bit once every sixteen ticks. Each recovered byte is stored in a sixteen-entry first-in first-out queue together with three error flags: parity, framing and break.

Software-visible control fields set the frame shape: a two-bit length code, a parity enable, an even/odd select and a fixed-parity select. The consumer reads the queue through a show-ahead port. While the queue is not empty, the oldest entry is on the outputs, and a read strobe removes it. If a byte completes while the queue is full, the byte is lost and a sticky flag reports the loss.

Top module: `uart_rx_fifo`

## Requirements
- R1: After reset, `empty` is 1 and `overrun` is 0.
- R2: A low level counts as a start bit only if the line is still low eight ticks after the tick that first saw it low. Otherwise the event leaves the queue and flags unchanged.
- R3: `len_sel` values 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. The first received data bit lands in `rd_data[0]`, and bits above the frame length read as 0.
- R4: With `par_en`=1 and `par_fixed`=0, `rd_perr` is 1 when the total count of ones in the data and parity bits is odd while `par_even`=1, or even while `par_even`=0.
- R5: With `par_en`=1 and `par_fixed`=1, the parity bit must be 0 when `par_even`=1 and 1 when `par_even`=0. Any other value sets `rd_perr`.
- R6: Only the first stop bit is sampled. A low first stop bit sets `rd_ferr`. Stop periods of 1, 1.5 or 2 bit times are all accepted.
- R7: `rd_brk` is 1 when the data bits, the parity bit (if present) and the first stop bit were all 0. Such an entry also has `rd_ferr`=1 and `rd_data`=0.
- R8: The queue holds 16 entries and returns them in arrival order. While `empty`=0 the oldest entry is on the read outputs. `rd_en` with `empty`=0 removes it, and `rd_en` has no effect while `empty`=1.
- R9: A frame that completes while the queue holds 16 entries is discarded, even if a read happens in the same cycle, and `overrun` goes to 1. `overrun` returns to 0 on the next read that removes an entry, unless another frame is discarded in that same cycle.
- R10: After a frame whose first stop bit was low, no new start bit is recognised until the line has been seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Enable pulse at 16x the bit rate |
| rxd | input | 1 | Serial input, idle high |
| len_sel | input | 2 | Data length code (0..3 for 5..8 bits) |
| par_en | input | 1 | Parity bit present |
| par_even | input | 1 | Even parity select / fixed parity value select |
| par_fixed | input | 1 | Fixed (stick) parity select |
| rd_en | input | 1 | Remove the oldest queue entry |
| rd_data | output | 8 | Oldest received byte |
| rd_perr | output | 1 | Parity error of the oldest entry |
| rd_ferr | output | 1 | Framing error of the oldest entry |
| rd_brk | output | 1 | Break indication of the oldest entry |
| empty | output | 1 | Queue holds no entries |
| overrun | output | 1 | A byte was lost to a full queue |

## Verification
A wrong sampling phase or bit counter corrupts the byte that appears at the head of the queue one stop-bit midpoint after the frame. A wrong parity or stop-bit check shows up as a flag on that same entry. A wrong queue pointer or occupancy count makes `empty`, the head contents or `overrun` disagree with an arrival-ordered model. The bench compares these on every clock between frames, so the mismatch is caught within a single frame time. If the receiver re-arms on a held-low line, extra break entries appear before the line returns high.

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int DEPTH = 16,
  parameter int OSR   = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rxd,
  input  logic [1:0] len_sel,
  input  logic       par_en,
  input  logic       par_even,
  input  logic       par_fixed,
  input  logic       rd_en,
  output logic [7:0] rd_data,
  output logic       rd_perr,
  output logic       rd_ferr,
  output logic       rd_brk,
  output logic       empty,
  output logic       overrun
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(OSR);

  typedef enum logic [2:0] {S_WAIT, S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  st_t           st;
  logic [1:0]    sync;
  logic [CW-1:0] cnt;
  logic [2:0]    bc;
  logic [7:0]    sh;
  logic          px, allz, perr;
  logic [10:0]   mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   fill;

  wire       rx      = sync[1];
  wire [3:0] nbits   = 4'd5 + {2'b00, len_sel};
  wire       bit_pt  = cnt == CW'(OSR - 1);
  wire [7:0] dat     = sh >> (4'd8 - nbits);
  wire       par_exp = par_fixed ? ~par_even : (par_even ? px : ~px);
  wire       full    = fill == (AW+1)'(DEPTH);
  wire       stop_pt = tick && st == S_STOP && bit_pt;
  wire       push    = stop_pt && !full;
  wire       drop    = stop_pt && full;
  wire       pop     = rd_en && !empty;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync <= 2'b11;
    else        sync <= {sync[0], rxd};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_WAIT; cnt <= '0; bc <= '0; sh <= '0;
      px <= 1'b0; allz <= 1'b1; perr <= 1'b0;
    end else if (tick) begin
      case (st)
        S_WAIT: if (rx) st <= S_IDLE;
        S_IDLE: if (!rx) begin st <= S_START; cnt <= '0; end
        S_START:
          if (cnt == CW'(OSR/2 - 1)) begin
            cnt <= '0; bc <= '0; px <= 1'b0; allz <= 1'b1; perr <= 1'b0;
            st  <= rx ? S_IDLE : S_DATA;
          end else cnt <= cnt + 1'b1;
        S_DATA: begin
          cnt <= bit_pt ? '0 : cnt + 1'b1;
          if (bit_pt) begin
            sh   <= {rx, sh[7:1]};
            px   <= px ^ rx;
            allz <= allz & ~rx;
            bc   <= bc + 1'b1;
            if (bc == 3'(nbits - 4'd1)) st <= par_en ? S_PAR : S_STOP;
          end
        end
        S_PAR: begin
          cnt <= bit_pt ? '0 : cnt + 1'b1;
          if (bit_pt) begin
            perr <= rx != par_exp;
            allz <= allz & ~rx;
            st   <= S_STOP;
          end
        end
        S_STOP: begin
          cnt <= bit_pt ? '0 : cnt + 1'b1;
          if (bit_pt) st <= rx ? S_IDLE : S_WAIT;
        end
        default: st <= S_WAIT;
      endcase
    end
  end

  always_ff @(posedge clk)
    if (push) mem[wp] <= {allz & ~rx, ~rx, perr, dat};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; fill <= '0; overrun <= 1'b0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      if (push && !pop)      fill <= fill + 1'b1;
      else if (pop && !push) fill <= fill - 1'b1;
      if (drop)     overrun <= 1'b1;
      else if (pop) overrun <= 1'b0;
    end
  end

  assign {rd_brk, rd_ferr, rd_perr, rd_data} = mem[rp];
  assign empty = fill == '0;
endmodule

module uart_rx_fifo_chk #(
  parameter int DEPTH = 16
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      empty,
  input logic                      overrun,
  input logic [7:0]                rd_data,
  input logic                      rd_brk,
  input logic                      rd_ferr,
  input logic [$clog2(DEPTH):0]    fill,
  input logic                      push,
  input logic                      drop,
  input logic                      pop
);
  p_fill_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= ($clog2(DEPTH)+1)'(DEPTH));

  p_pop_shrinks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |=> fill == $past(fill) - 1'b1);

  p_empty_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !push) |=> empty);

  p_ovr_only_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(fill) == ($clog2(DEPTH)+1)'(DEPTH));

  p_ovr_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !drop) |=> !overrun);

  p_brk_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty && rd_brk) |-> (rd_ferr && rd_data == 8'h00));
endmodule

bind uart_rx_fifo uart_rx_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .empty(empty), .overrun(overrun),
  .rd_data(rd_data), .rd_brk(rd_brk), .rd_ferr(rd_ferr),
  .fill(fill), .push(push), .drop(drop), .pop(pop)
);

// File: tb/uart_rx_fifo_tb.sv
module uart_rx_fifo_tb;
  logic clk = 0, rst_n = 0, rxd = 1, rd_en = 0;
  logic [1:0] len_sel = 2'd3;
  logic par_en = 0, par_even = 0, par_fixed = 0;
  logic [7:0] rd_data;
  logic rd_perr, rd_ferr, rd_brk, empty, overrun;
  logic [1:0] tdiv = 0;
  wire tick = tdiv == 2'd3;

  int nchk = 0, nfail = 0, cycles = 0;
  bit cmp_en = 0;
  bit exp_ovr = 0;
  logic [10:0] q[$];

  uart_rx_fifo u_dut (.*);

  always #5 clk = ~clk;
  always @(posedge clk) tdiv <= tdiv + 1'b1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (cmp_en) begin
    chk("R8 empty", {31'd0, empty}, {31'd0, q.size() == 0});
    chk("R9 overrun", {31'd0, overrun}, {31'd0, exp_ovr});
    if (q.size() > 0 && !empty)
      chk("R8 head", {21'd0, rd_brk, rd_ferr, rd_perr, rd_data}, {21'd0, q[0]});
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      nfail++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  task automatic hold(input logic v, input int ticks);
    rxd = v;
    repeat (ticks * 4) @(negedge clk);
  endtask

  function automatic logic good_par(input logic [7:0] d);
    if (par_fixed) return ~par_even;
    return par_even ? ^d : ~^d;
  endfunction

  function automatic logic [10:0] expect_word(input logic [7:0] d, input int nb,
                                              input logic pbit, input logic stop);
    logic [7:0] m;
    logic pe, br;
    m  = d & 8'((1 << nb) - 1);
    pe = par_en && (pbit != good_par(m));
    br = !stop && m == 0 && (!par_en || !pbit);
    return {br, !stop, pe, m};
  endfunction

  task automatic send(input logic [7:0] d, input logic pbit, input logic stop,
                      input int stop_ticks, input int idle_ticks);
    int nb;
    nb = 5 + len_sel;
    cmp_en = 0;
    hold(1'b0, 16);
    for (int i = 0; i < nb; i++) hold(d[i], 16);
    if (par_en) hold(pbit, 16);
    hold(stop, stop_ticks);
    if (q.size() == 16) exp_ovr = 1;
    else q.push_back(expect_word(d, nb, pbit, stop));
    hold(1'b1, idle_ticks);
    cmp_en = 1;
  endtask

  task automatic pop_one(input string tag, input logic [10:0] exp);
    @(negedge clk);
    chk(tag, {21'd0, rd_brk, rd_ferr, rd_perr, rd_data}, {21'd0, exp});
    rd_en = 1;
    @(posedge clk); #1;
    void'(q.pop_front());
    exp_ovr = 0;
    @(negedge clk) rd_en = 0;
  endtask

  task automatic drain();
    while (q.size() > 0) pop_one("R8 order", q[0]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 empty", {31'd0, empty}, 32'd1);
    chk("R1 overrun", {31'd0, overrun}, 32'd0);
    rst_n = 1;
    repeat (8) @(negedge clk);
    cmp_en = 1;

    // R3 8-bit, LSB first
    len_sel = 2'd3;
    send(8'hA5, 0, 1, 16, 16);
    pop_one("R3 8bit", {3'b000, 8'hA5});
    // R3 5-bit, upper bits zero
    len_sel = 2'd0;
    send(8'hF3, 0, 1, 16, 16);
    pop_one("R3 5bit", {3'b000, 8'h13});
    len_sel = 2'd1;
    send(8'h2D, 0, 1, 16, 16);
    pop_one("R3 6bit", {3'b000, 8'h2D});

    // R4 normal parity
    len_sel = 2'd2; par_en = 1; par_fixed = 0; par_even = 1;
    send(8'h35, 1'b0, 1, 16, 16);
    pop_one("R4 even ok", {3'b000, 8'h35});
    send(8'h35, 1'b1, 1, 16, 16);
    pop_one("R4 even bad", {3'b001, 8'h35});
    par_even = 0;
    send(8'h35, 1'b1, 1, 16, 16);
    pop_one("R4 odd ok", {3'b000, 8'h35});
    send(8'h35, 1'b0, 1, 16, 16);
    pop_one("R4 odd bad", {3'b001, 8'h35});

    // R5 fixed parity
    par_fixed = 1; par_even = 1;
    send(8'h7F, 1'b0, 1, 16, 16);
    pop_one("R5 fixed0 ok", {3'b000, 8'h7F});
    send(8'h7F, 1'b1, 1, 16, 16);
    pop_one("R5 fixed0 bad", {3'b001, 8'h7F});
    par_even = 0;
    send(8'h00, 1'b1, 1, 16, 16);
    pop_one("R5 fixed1 ok", {3'b000, 8'h00});
    send(8'h00, 1'b0, 1, 16, 16);
    pop_one("R5 fixed1 bad", {3'b001, 8'h00});
    par_en = 0; par_fixed = 0;

    // R6 framing and stop lengths
    len_sel = 2'd3;
    send(8'h5A, 0, 0, 16, 16);
    pop_one("R6 ferr", {3'b010, 8'h5A});
    len_sel = 2'd0;
    send(8'h0B, 0, 1, 24, 0);
    send(8'h14, 0, 1, 32, 16);
    pop_one("R6 1.5 stop", {3'b000, 8'h0B});
    pop_one("R6 2 stop", {3'b000, 8'h14});

    // R7 / R10 break held low
    len_sel = 2'd3;
    cmp_en = 0;
    hold(1'b0, 16 * 14);
    q.push_back({3'b110, 8'h00});
    hold(1'b1, 16);
    cmp_en = 1;
    pop_one("R7 break", {3'b110, 8'h00});
    @(negedge clk);
    chk("R10 single entry", {31'd0, empty}, 32'd1);

    // R2 glitch ignored
    hold(1'b0, 4);
    hold(1'b1, 24);
    chk("R2 glitch", {31'd0, empty}, 32'd1);
    @(negedge clk) rd_en = 1;
    @(negedge clk) rd_en = 0;
    chk("R8 read on empty", {31'd0, empty}, 32'd1);

    // R8 / R9 fill and overrun
    for (int i = 0; i < 17; i++) send(8'(8'h30 + i), 0, 1, 16, 4);
    chk("R9 overrun set", {31'd0, overrun}, 32'd1);
    chk("R8 full count", q.size(), 32'd16);
    pop_one("R8 first", {3'b000, 8'h30});
    chk("R9 overrun cleared", {31'd0, overrun}, 32'd0);
    drain();
    repeat (4) @(negedge clk);
    chk("R8 drained", {31'd0, empty}, 32'd1);
    send(8'hC3, 0, 1, 16, 16);
    pop_one("R8 after wrap", {3'b000, 8'hC3});

    cmp_en = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule